// File: doc/BRIEF.md
# Floating-Point Exception Capture and Interrupt Gate

This block holds the exception state that a floating-point microcode sequencer and its surrounding hardware share. While an instruction runs, the microcode reports each exceptional condition with a raise command that names one of six classes. The condition is stored in a per-instruction capture latch. The capture latches are cleared when the next instruction begins. When the instruction's routine finishes, they are merged into a set of sticky status flags that software can read.

A six-bit mask vector comes from the control register that sits outside this block. The block combines the mask with the capture latches and the existing status flags to find exceptions that are unmasked and not yet recorded. It gives this result to the microcode as a combinational "unmasked pending" branch condition. When such an exception first appears, the block raises an interrupt request toward the host. The request stays raised until the host acknowledges it. A masked exception is captured and later recorded in the status flags, but it never interrupts, so execution continues.

Class codes on `raise_cls` are: 0 invalid operation, 1 denormal operand, 2 divide by zero, 3 overflow, 4 underflow, 5 precision. Bit k of `exc_mask`, `exc_latch` and `sts_flags` belongs to class code k.

Top module: `fpx_exc_unit`

## Requirements
- R1: After reset, `exc_latch`, `sts_flags`, `irq_req` and `unm_pend` are all zero.
- R2: A cycle with `raise_vld` high and `raise_cls` = k (0..5) sets bit k of `exc_latch` from the next cycle on. Codes 6 and 7 leave `exc_latch` unchanged. Latch bits otherwise hold.
- R3: `instr_start` clears every `exc_latch` bit at the next edge. A raise in the same cycle belongs to the new instruction, so its bit is set.
- R4: `unm_pend` is high in the same cycle whenever some class has its `exc_latch` bit set, its `exc_mask` bit clear and its `sts_flags` bit clear.
- R5: When a class newly meets the R4 condition, `irq_req` rises one cycle after that condition first appears.
- R6: A raise for a class whose mask bit is set captures the latch bit but raises neither `unm_pend` nor `irq_req`.
- R7: A raise for a class whose status flag is already set raises neither `unm_pend` nor `irq_req`.
- R8: `irq_req` stays high until a cycle with `irq_ack`. After that cycle it is low, unless a class newly met the R4 condition in the acknowledge cycle, in which case it stays high.
- R9: `instr_end` ORs `exc_latch` into `sts_flags` at the next edge. Status bits are sticky: `instr_start` and later instructions do not clear them.
- R10: `sts_clr` clears `sts_flags`. When `sts_clr` and `instr_end` come in the same cycle, `sts_flags` becomes exactly the current `exc_latch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| raise_vld | input | 1 | Raise command from microcode |
| raise_cls | input | 3 | Exception class code of the raise |
| instr_start | input | 1 | First cycle of a new instruction; clears capture latches |
| instr_end | input | 1 | End of routine; merges latches into status |
| exc_mask | input | 6 | Per-class mask bits from the control register |
| sts_clr | input | 1 | Clears the sticky status flags |
| irq_ack | input | 1 | Host acknowledge of the interrupt request |
| exc_latch | output | 6 | Per-instruction capture latches |
| sts_flags | output | 6 | Sticky status exception flags |
| unm_pend | output | 1 | Combinational unmasked-pending branch condition |
| irq_req | output | 1 | Interrupt request to the host |

## Verification
Two functions can fall in the same cycle and must be resolved explicitly. The first pair is the host acknowledge and the arrival of a fresh unmasked class. The bench leaves one interrupt outstanding, raises overflow, and acknowledges in the cycle in which that overflow first becomes pending; it expects the request to stay high, and a second acknowledge to drop it. The second pair is a status clear together with an end of routine: the bench expects the status to equal exactly the latches of the finishing instruction. A new instruction start together with a raise is also checked; only the newly raised class should remain.

// File: rtl/fpx_exc_pkg.sv
package fpx_exc_pkg;

  localparam int unsigned FPX_NUM_CLS = 6;
  localparam int unsigned FPX_CLS_W   = $clog2(FPX_NUM_CLS);

  // Class codes; bit k of every per-class vector belongs to code k.
  typedef enum logic [FPX_CLS_W-1:0] {
    FPX_CLS_INVALID = 3'd0,
    FPX_CLS_DENORM  = 3'd1,
    FPX_CLS_ZDIV    = 3'd2,
    FPX_CLS_OVFL    = 3'd3,
    FPX_CLS_UNFL    = 3'd4,
    FPX_CLS_PREC    = 3'd5
  } fpx_cls_e;

endpackage

// File: rtl/fpx_exc_latch.sv
module fpx_exc_latch #(
  parameter int unsigned NUM_CLS = fpx_exc_pkg::FPX_NUM_CLS,
  parameter int unsigned CLS_W   = fpx_exc_pkg::FPX_CLS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_vld,
  input  logic [CLS_W-1:0]   raise_cls,
  input  logic               instr_start,
  output logic [NUM_CLS-1:0] latch_q
);

  logic [NUM_CLS-1:0] hit;
  logic [NUM_CLS-1:0] latch_d;
  logic               latch_en;

  // One decoder per class; codes beyond NUM_CLS-1 match nothing.
  for (genvar g = 0; g < NUM_CLS; g++) begin : g_dec
    assign hit[g] = raise_vld && (raise_cls == CLS_W'(g));
  end

  always_comb begin
    latch_en = instr_start || (|hit);
    latch_d  = (instr_start ? '0 : latch_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

endmodule

// File: rtl/fpx_exc_status.sv
module fpx_exc_status #(
  parameter int unsigned NUM_CLS = fpx_exc_pkg::FPX_NUM_CLS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fold_en,
  input  logic               clr,
  input  logic [NUM_CLS-1:0] latch_in,
  output logic [NUM_CLS-1:0] sts_q
);

  logic [NUM_CLS-1:0] sts_d;
  logic               sts_en;

  always_comb begin
    sts_en = fold_en || clr;
    sts_d  = (clr ? '0 : sts_q) | (fold_en ? latch_in : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

endmodule

// File: rtl/fpx_exc_irq.sv
module fpx_exc_irq #(
  parameter int unsigned NUM_CLS = fpx_exc_pkg::FPX_NUM_CLS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLS-1:0] latch_in,
  input  logic [NUM_CLS-1:0] mask_in,
  input  logic [NUM_CLS-1:0] sts_in,
  input  logic               ack,
  output logic               unm_pend,
  output logic               irq_req
);

  logic [NUM_CLS-1:0] pend_vec;
  logic [NUM_CLS-1:0] pend_q;
  logic               fire;
  logic               irq_d;
  logic               irq_en;

  always_comb begin
    pend_vec = latch_in & ~mask_in & ~sts_in;
    unm_pend = |pend_vec;
    fire     = |(pend_vec & ~pend_q);
    irq_en   = fire || ack;
    irq_d    = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
    end else if (irq_en) begin
      irq_req <= irq_d;
    end
  end

endmodule

// File: rtl/fpx_exc_unit.sv
module fpx_exc_unit #(
  parameter int unsigned NUM_CLS = fpx_exc_pkg::FPX_NUM_CLS,
  localparam int unsigned CLS_W  = $clog2(NUM_CLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_vld,
  input  logic [CLS_W-1:0]   raise_cls,
  input  logic               instr_start,
  input  logic               instr_end,
  input  logic [NUM_CLS-1:0] exc_mask,
  input  logic               sts_clr,
  input  logic               irq_ack,
  output logic [NUM_CLS-1:0] exc_latch,
  output logic [NUM_CLS-1:0] sts_flags,
  output logic               unm_pend,
  output logic               irq_req
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  fpx_exc_latch #(.NUM_CLS(NUM_CLS), .CLS_W(CLS_W)) i_latch (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .raise_vld   (raise_vld),
    .raise_cls   (raise_cls),
    .instr_start (instr_start),
    .latch_q     (exc_latch)
  );

  fpx_exc_status #(.NUM_CLS(NUM_CLS)) i_status (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .fold_en  (instr_end),
    .clr      (sts_clr),
    .latch_in (exc_latch),
    .sts_q    (sts_flags)
  );

  fpx_exc_irq #(.NUM_CLS(NUM_CLS)) i_irq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .latch_in (exc_latch),
    .mask_in  (exc_mask),
    .sts_in   (sts_flags),
    .ack      (irq_ack),
    .unm_pend (unm_pend),
    .irq_req  (irq_req)
  );

endmodule

// File: rtl/fpx_exc_chk.sv
module fpx_exc_chk #(
  parameter int unsigned NUM_CLS = 6,
  parameter int unsigned CLS_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               raise_vld,
  input logic [CLS_W-1:0]   raise_cls,
  input logic               instr_start,
  input logic               instr_end,
  input logic [NUM_CLS-1:0] exc_mask,
  input logic               sts_clr,
  input logic               irq_ack,
  input logic [NUM_CLS-1:0] exc_latch,
  input logic [NUM_CLS-1:0] sts_flags,
  input logic               unm_pend,
  input logic               irq_req
);

  logic bad_code;
  assign bad_code = raise_vld && (32'(raise_cls) >= NUM_CLS);

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_start && !raise_vld) |=> $stable(exc_latch)); // R2

  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_start && bad_code) |=> $stable(exc_latch)); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_start && !raise_vld) |=> (exc_latch == '0)); // R3

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !$past(irq_req)) |-> $past(unm_pend)); // R5

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req); // R8

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !unm_pend) |=> !irq_req); // R8

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_clr |=> ((sts_flags & $past(sts_flags)) == $past(sts_flags))); // R9

  AST_END_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    instr_end |=> ((sts_flags & $past(exc_latch)) == $past(exc_latch))); // R9

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !instr_end) |=> (sts_flags == '0)); // R10

endmodule

bind fpx_exc_unit fpx_exc_chk #(.NUM_CLS(NUM_CLS), .CLS_W(CLS_W)) i_fpx_exc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .raise_vld   (raise_vld),
  .raise_cls   (raise_cls),
  .instr_start (instr_start),
  .instr_end   (instr_end),
  .exc_mask    (exc_mask),
  .sts_clr     (sts_clr),
  .irq_ack     (irq_ack),
  .exc_latch   (exc_latch),
  .sts_flags   (sts_flags),
  .unm_pend    (unm_pend),
  .irq_req     (irq_req)
);

// File: tb/test_fpx_exc_unit.sv
module test_fpx_exc_unit;

  logic       clk;
  logic       rst_n;
  logic       raise_vld;
  logic [2:0] raise_cls;
  logic       instr_start;
  logic       instr_end;
  logic [5:0] exc_mask;
  logic       sts_clr;
  logic       irq_ack;
  logic [5:0] exc_latch;
  logic [5:0] sts_flags;
  logic       unm_pend;
  logic       irq_req;

  typedef struct {
    int         due;
    logic [5:0] lat;
    logic [5:0] sts;
    logic       irq;
    logic       pend;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc;
  int   n_chk;
  int   n_fail;
  bit   done;

  fpx_exc_unit i_fpx_exc_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_vld   (raise_vld),
    .raise_cls   (raise_cls),
    .instr_start (instr_start),
    .instr_end   (instr_end),
    .exc_mask    (exc_mask),
    .sts_clr     (sts_clr),
    .irq_ack     (irq_ack),
    .exc_latch   (exc_latch),
    .sts_flags   (sts_flags),
    .unm_pend    (unm_pend),
    .irq_req     (irq_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: 1 ns after each edge, compare every item due in this cycle.
  always @(posedge clk) begin
    #1;
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (exc_latch !== e.lat || sts_flags !== e.sts ||
          irq_req !== e.irq || unm_pend !== e.pend) begin
        n_fail++;
        $display("FAIL %s: latch=%h sts=%h irq=%b pend=%b expected latch=%h sts=%h irq=%b pend=%b",
                 e.req, exc_latch, sts_flags, irq_req, unm_pend,
                 e.lat, e.sts, e.irq, e.pend);
      end
    end
  end

  // Driver: apply one cycle of stimulus and queue the state expected after the edge.
  task automatic step(input logic rv, input logic [2:0] rc, input logic st,
                      input logic en, input logic cl, input logic ak,
                      input logic [5:0] mk, input logic [5:0] el,
                      input logic [5:0] es, input logic ei, input logic ep,
                      input string rq);
    exp_t e;
    @(posedge clk);
    #2;
    raise_vld = rv; raise_cls = rc; instr_start = st; instr_end = en;
    sts_clr = cl; irq_ack = ak; exc_mask = mk;
    e.due = cyc + 1; e.lat = el; e.sts = es; e.irq = ei; e.pend = ep; e.req = rq;
    exp_q.push_back(e);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc = 0; n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; raise_vld = 0; raise_cls = 0; instr_start = 0; instr_end = 0;
    exc_mask = 6'h00; sts_clr = 0; irq_ack = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    //    rv rc  st en cl ak mask   latch  sts    irq pend
    step(0, 0, 0, 0, 0, 0, 6'h00, 6'h00, 6'h00, 0, 0, "R1 reset state");
    step(1, 0, 0, 0, 0, 0, 6'h00, 6'h01, 6'h00, 0, 1, "R2 R4 invalid raised");
    step(0, 0, 0, 0, 0, 0, 6'h00, 6'h01, 6'h00, 1, 1, "R5 irq one cycle later");
    step(0, 0, 0, 0, 0, 0, 6'h00, 6'h01, 6'h00, 1, 1, "R8 irq held");
    step(0, 0, 0, 0, 0, 1, 6'h00, 6'h01, 6'h00, 0, 1, "R8 ack drops irq");
    step(0, 0, 0, 1, 0, 0, 6'h00, 6'h01, 6'h01, 0, 0, "R9 end folds latch");
    step(0, 0, 1, 0, 0, 0, 6'h00, 6'h00, 6'h01, 0, 0, "R3 R9 start clears latch, status sticky");
    step(1, 0, 0, 0, 0, 0, 6'h00, 6'h01, 6'h01, 0, 0, "R7 flag already set, no pend");
    step(0, 0, 0, 0, 0, 0, 6'h00, 6'h01, 6'h01, 0, 0, "R7 flag already set, no irq");
    step(0, 0, 0, 0, 1, 0, 6'h00, 6'h01, 6'h00, 0, 1, "R10 clear status");
    step(0, 0, 0, 0, 0, 0, 6'h00, 6'h01, 6'h00, 1, 1, "R5 irq after flag cleared");
    step(1, 3, 0, 0, 0, 0, 6'h00, 6'h09, 6'h00, 1, 1, "R2 overflow raised");
    step(0, 0, 0, 0, 0, 1, 6'h00, 6'h09, 6'h00, 1, 1, "R8 ack with new pending keeps irq");
    step(0, 0, 0, 0, 0, 1, 6'h00, 6'h09, 6'h00, 0, 1, "R8 second ack drops irq");
    step(0, 0, 1, 0, 0, 0, 6'h20, 6'h00, 6'h00, 0, 0, "R3 start clears");
    step(1, 5, 0, 0, 0, 0, 6'h20, 6'h20, 6'h00, 0, 0, "R6 masked precision captured");
    step(0, 0, 0, 0, 0, 0, 6'h20, 6'h20, 6'h00, 0, 0, "R6 masked no irq");
    step(1, 6, 0, 0, 0, 0, 6'h20, 6'h20, 6'h00, 0, 0, "R2 code 6 ignored");
    step(1, 7, 0, 0, 0, 0, 6'h20, 6'h20, 6'h00, 0, 0, "R2 code 7 ignored");
    step(1, 2, 1, 0, 0, 0, 6'h20, 6'h04, 6'h00, 0, 1, "R3 start with raise keeps new class");
    step(0, 0, 0, 0, 0, 0, 6'h20, 6'h04, 6'h00, 1, 1, "R5 zero divide irq");
    step(0, 0, 0, 0, 0, 1, 6'h20, 6'h04, 6'h00, 0, 1, "R8 ack");
    step(0, 0, 0, 1, 0, 0, 6'h20, 6'h04, 6'h04, 0, 0, "R9 end folds zero divide");
    step(0, 0, 1, 0, 0, 0, 6'h20, 6'h00, 6'h04, 0, 0, "R9 status sticky over start");
    step(1, 1, 0, 0, 0, 0, 6'h20, 6'h02, 6'h04, 0, 1, "R4 denormal pending");
    step(0, 0, 0, 0, 0, 0, 6'h20, 6'h02, 6'h04, 1, 1, "R5 denormal irq");
    step(0, 0, 0, 1, 1, 0, 6'h20, 6'h02, 6'h02, 1, 0, "R10 clear with end gives latch");
    step(0, 0, 0, 0, 0, 1, 6'h20, 6'h02, 6'h02, 0, 0, "R8 final ack");
    step(0, 0, 1, 0, 0, 0, 6'h20, 6'h00, 6'h02, 0, 0, "R3 final start");
    step(0, 0, 0, 0, 0, 0, 6'h20, 6'h00, 6'h02, 0, 0, "R1 idle");
    repeat (3) @(posedge clk);
    #3;
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 scoreboard: %0d items left, expected 0", exp_q.size());
    end
    done = 1;
    finish_run();
  end

endmodule